// File: doc/BRIEF.md
# Unified Shift and Rotate Unit

This block is the shift section of a processor ALU. It takes one 32-bit operand, a shift amount, a direction bit and two control bits that come straight from the top two bits of the instruction word. From these it produces a zero-filling logical shift, a one-filling logical shift, an arithmetic right shift or a rotate. All of them pass through one chain of five conditional shift stages, and each stage moves the data by 1, 2, 4, 8 or 16 places.

The upper control bit (instruction bit 31) is used directly as the value that a logical shift inserts. The lower control bit (instruction bit 30) changes a zero-fill shift into an arithmetic shift, and changes a one-fill shift into a rotate. An arithmetic shift to the left is not defined. The unit flags that combination as illegal so that the decoder can give the slot to another operation. The result and the flag are registered, so they appear one clock after the inputs.

Top module: `shrot_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` and `illegal_o` become zero at that edge.
- R2: The result for the inputs presented at a rising edge appears on `res_o` and `illegal_o` immediately after that edge, with a latency of one cycle.
- R3: With control {`ctl_hi_i`,`ctl_lo_i`} = 00, the operand is shifted left (`dir_left_i`=1) or right (`dir_left_i`=0), and every vacated position is set to 0.
- R4: With control 01 and `dir_left_i`=0, the operand is shifted right, and every vacated position takes a copy of operand bit 31.
- R5: With control 10, the operand is shifted in the selected direction, and every vacated position is set to 1.
- R6: With control 11, the operand is rotated in the selected direction. Bits that leave one end come back in at the other end in the same order, and the number of set bits is kept.
- R7: With control 01 and `dir_left_i`=1, `illegal_o` is 1 and `res_o` is all zeros. For every other combination, `illegal_o` is 0.
- R8: A shift amount of 0 gives back the operand unchanged in every legal mode.
- R9: Only the low 5 bits of `amt_i` count. A value whose bit 5 is set gives the same result as the same value with bit 5 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opnd_i | input | 32 | Operand to shift or rotate |
| amt_i | input | 6 | Shift amount; only bits 4:0 are used |
| dir_left_i | input | 1 | 1 = toward the MSB, 0 = toward the LSB |
| ctl_hi_i | input | 1 | Instruction bit 31: fill value for logical shifts, and the rotate group |
| ctl_lo_i | input | 1 | Instruction bit 30: arithmetic or rotate select |
| res_o | output | 32 | Registered result |
| illegal_o | output | 1 | Registered flag for the undefined arithmetic-left slot |

## Verification
The assertions check a set of invariants on every cycle:
- The flag follows its decode, and a flagged result is zero.
- A zero amount passes the operand through.
- An arithmetic right shift keeps the sign bit.
- A rotate keeps the number of set bits.
- A zero-fill shift never adds ones, and a one-fill shift never adds zeros.

Those invariants cannot show that bits land in the right positions, that a rotate wraps in the correct order, or that amount bit 5 is ignored. Only the bench's bit-exact comparisons can show these, made over directed corner cases and over seeded random operands across all modes and directions.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  // control pair {instruction bit 31, instruction bit 30}
  typedef enum logic [1:0] {
    MODE_ZFILL = 2'b00,
    MODE_ARITH = 2'b01,
    MODE_OFILL = 2'b10,
    MODE_ROT   = 2'b11
  } shrot_mode_e;
endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
(
  input  logic ctl_hi,
  input  logic ctl_lo,
  input  logic left,
  input  logic sign,
  output logic wrap,
  output logic fill,
  output logic bad
);
  shrot_mode_e mode;

  always_comb begin
    mode = shrot_mode_e'({ctl_hi, ctl_lo});
    wrap = 1'b0;
    fill = 1'b0;
    bad  = 1'b0;
    case (mode)
      MODE_ZFILL: fill = ctl_hi;
      MODE_OFILL: fill = ctl_hi;
      MODE_ARITH: begin
        fill = sign;
        bad  = left;
      end
      MODE_ROT:   wrap = 1'b1;
      default:    fill = 1'b0;
    endcase
  end
endmodule

// File: rtl/shrot_stage.sv
module shrot_stage #(
  parameter int XLEN = 32,
  parameter int STEP = 1
) (
  input  logic [XLEN-1:0] d,
  input  logic            en,
  input  logic            left,
  input  logic            wrap,
  input  logic            fill,
  output logic [XLEN-1:0] q
);
  logic [XLEN-1:0] to_right;
  logic [XLEN-1:0] to_left;

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    // move toward the LSB: the source is STEP places above
    if (i + STEP < XLEN) begin : g_r_in
      assign to_right[i] = d[i+STEP];
    end else begin : g_r_edge
      assign to_right[i] = wrap ? d[i+STEP-XLEN] : fill;
    end
    // move toward the MSB: the source is STEP places below
    if (i >= STEP) begin : g_l_in
      assign to_left[i] = d[i-STEP];
    end else begin : g_l_edge
      assign to_left[i] = wrap ? d[i-STEP+XLEN] : fill;
    end
  end

  assign q = !en ? d : (left ? to_left : to_right);
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int XLEN     = 32,
  parameter int AMT_IN_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [XLEN-1:0]     opnd_i,
  input  logic [AMT_IN_W-1:0] amt_i,
  input  logic                dir_left_i,
  input  logic                ctl_hi_i,
  input  logic                ctl_lo_i,
  output logic [XLEN-1:0]     res_o,
  output logic                illegal_o
);
  localparam int SH_W = $clog2(XLEN);

  logic            wrap, fill, bad;
  logic [XLEN-1:0] chain [SH_W+1];
  logic [XLEN-1:0] next_res;

  // R9: amount bits above SH_W take no part in the datapath
  logic unused_amt_hi;
  assign unused_amt_hi = ^amt_i[AMT_IN_W-1:SH_W];

  shrot_ctrl u_ctrl (
    .ctl_hi (ctl_hi_i),
    .ctl_lo (ctl_lo_i),
    .left   (dir_left_i),
    .sign   (opnd_i[XLEN-1]),
    .wrap   (wrap),
    .fill   (fill),
    .bad    (bad)
  );

  assign chain[0] = opnd_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    shrot_stage #(.XLEN(XLEN), .STEP(1 << k)) u_stage (
      .d    (chain[k]),
      .en   (amt_i[k]),
      .left (dir_left_i),
      .wrap (wrap),
      .fill (fill),
      .q    (chain[k+1])
    );
  end

  assign next_res = bad ? '0 : chain[SH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      illegal_o <= 1'b0;
    end else begin
      res_o     <= next_res;
      illegal_o <= bad;
    end
  end

  // R7
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_hi_i && ctl_lo_i && dir_left_i) |=> illegal_o);
  // R7
  legal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !(!ctl_hi_i && ctl_lo_i && dir_left_i) |=> !illegal_o);
  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (res_o == '0));
  // R8
  zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
    (amt_i[SH_W-1:0] == '0 && !(!ctl_hi_i && ctl_lo_i && dir_left_i))
    |=> res_o == $past(opnd_i));
  // R4
  arith_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_hi_i && ctl_lo_i && !dir_left_i)
    |=> res_o[XLEN-1] == $past(opnd_i[XLEN-1]));
  // R6
  rot_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_hi_i && ctl_lo_i)
    |=> $countones(res_o) == $countones($past(opnd_i)));
  // R3
  zfill_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_hi_i && !ctl_lo_i)
    |=> $countones(res_o) <= $countones($past(opnd_i)));
  // R5
  ofill_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_hi_i && !ctl_lo_i)
    |=> $countones(res_o) >= $countones($past(opnd_i)));
endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] opnd;
  logic [5:0]  amt;
  logic        left, hi, lo;
  logic [31:0] res;
  logic        illegal;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shrot_unit u_dut (
    .clk        (clk),
    .rst        (rst),
    .opnd_i     (opnd),
    .amt_i      (amt),
    .dir_left_i (left),
    .ctl_hi_i   (hi),
    .ctl_lo_i   (lo),
    .res_o      (res),
    .illegal_o  (illegal)
  );

  function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [5:0] sh,
                                          input logic l, input logic h, input logic o);
    int n = int'(sh[4:0]);
    logic [31:0] r;
    logic f;
    if (!h && o && l) return 32'h0;
    f = h ? 1'b1 : (o ? a[31] : 1'b0);
    for (int i = 0; i < 32; i++) begin
      int s = l ? i - n : i + n;
      if (s >= 0 && s < 32) r[i] = a[s];
      else if (h && o) r[i] = a[(s + 32) % 32];
      else r[i] = f;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] a, input logic [5:0] sh,
                     input logic l, input logic h, input logic o);
    @(negedge clk);
    opnd = a; amt = sh; left = l; hi = h; lo = o;
    @(negedge clk);
    check(req, res, ref_res(a, sh, l, h, o));
    check({req, " flag"}, {31'd0, illegal}, {31'd0, (!h && o && l)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst = 1'b1; opnd = 32'hffffffff; amt = 6'd3; left = 1'b0; hi = 1'b1; lo = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset clears outputs
    check("R1 reset res", res, 32'h0);
    check("R1 reset flag", {31'd0, illegal}, 32'h0);
    rst = 1'b0;

    // R2: one-cycle latency, result visible after a single edge
    run("R2 latency", 32'h80000001, 6'd1, 1'b1, 1'b0, 1'b0);
    // R3 zero fill
    run("R3 zfill left", 32'hf000000f, 6'd4, 1'b1, 1'b0, 1'b0);
    run("R3 zfill right", 32'hf000000f, 6'd31, 1'b0, 1'b0, 1'b0);
    // R4 arithmetic right, negative and positive
    run("R4 arith neg", 32'h80001234, 6'd8, 1'b0, 1'b0, 1'b1);
    run("R4 arith pos", 32'h7fff0000, 6'd31, 1'b0, 1'b0, 1'b1);
    // R5 ones fill
    run("R5 ofill left", 32'h00000000, 6'd5, 1'b1, 1'b1, 1'b0);
    run("R5 ofill right", 32'h12345678, 6'd16, 1'b0, 1'b1, 1'b0);
    // R6 rotate
    run("R6 rot left", 32'h80000001, 6'd1, 1'b1, 1'b1, 1'b1);
    run("R6 rot right", 32'h12345678, 6'd12, 1'b0, 1'b1, 1'b1);
    run("R6 rot right 31", 32'h00000001, 6'd31, 1'b0, 1'b1, 1'b1);
    // R7 illegal slot, then legal again
    run("R7 illegal", 32'hdeadbeef, 6'd7, 1'b1, 1'b0, 1'b1);
    run("R7 illegal amt0", 32'hdeadbeef, 6'd0, 1'b1, 1'b0, 1'b1);
    run("R7 legal after", 32'hdeadbeef, 6'd7, 1'b0, 1'b0, 1'b1);
    // R8 zero amount in every legal mode
    for (int m = 0; m < 8; m++) begin
      if (m != 3) run("R8 amt0", 32'h9abcdef0, 6'd0, m[0], m[2], m[1]);
    end
    // R9 amount bit 5 ignored
    run("R9 hi amt rot", 32'h12345678, 6'h24, 1'b1, 1'b1, 1'b1);
    run("R9 hi amt zfill", 32'hffffffff, 6'h20, 1'b0, 1'b0, 1'b0);
    run("R9 hi amt ofill", 32'h0000ff00, 6'h3f, 1'b0, 1'b1, 1'b0);

    // random sweep over all modes (R3 R4 R5 R6 R7 R9)
    for (int t = 0; t < 2000; t++) begin
      logic [2:0] m = 3'($urandom);
      run("R3-6 random", $urandom, 6'($urandom), m[0], m[2], m[1]);
    end

    // R1: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", res, 32'h0);
    check("R1 reset flag again", {31'd0, illegal}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule